// File: doc/BRIEF.md
# Debug Next-PC Shadow Cache

This block sits between a debug access port and the special-purpose register interface of a processor core that a debugger halts and resumes. It serves debugger reads and writes of two program-counter registers. One is the next-PC, the address of the instruction that will next reach write-back. The other is the previous-PC, the address of the instruction that has just left write-back. Writing the next-PC of a halted core flushes its pipeline. Until the core runs again, its live next-PC then reads as zero, and a debugger expects to read back what it wrote.

While the core is stalled the block therefore holds a shadow copy of the next-PC. It loads the copy from the core when the stall begins and replaces it on every forwarded write. Reads of the next-PC are answered from the copy. A write of the value already held is dropped, so it cannot flush the pipeline and lose a pending delayed branch. A write of a different value is sent to the core as a one-cycle redirect carrying the new target, and the core flushes on that redirect. When the core leaves the stalled state the copy is invalidated and all accesses pass through to the core again.

Top module: `pc_shadow_bridge`

## Requirements
- R1: After reset, `dbg_rsp_valid` and `core_redirect_valid` are low and `dbg_req_ready` is high.
- R2: A request accepted on a clock edge (`dbg_req_valid` and `dbg_req_ready` both high) is answered with `dbg_rsp_valid` high for exactly the next cycle, and `dbg_req_ready` is low during that response cycle. A write returns read data zero.
- R3: `dbg_req_sel` = 0 selects the next-PC and 1 selects the previous-PC. On the first edge at which `core_stalled` is seen high, the shadow loads `core_npc`. A next-PC read while stalled then returns that value, whatever `core_npc` shows afterwards.
- R4: A next-PC write while stalled whose data differs from the shadow raises `core_redirect_valid` for exactly one cycle, in the cycle after acceptance, with `core_redirect_pc` equal to the write data.
- R5: After such a write, next-PC reads while still stalled return the written value, even when `core_npc` reads zero.
- R6: A next-PC write while stalled whose data equals the shadow produces no redirect and leaves the value returned by later reads unchanged.
- R7: While the core is running, next-PC reads return `core_npc`. Next-PC writes are always redirected, including writes of the current value.
- R8: On leaving the stall the shadow is invalidated. Reads pass through to `core_npc`, and the next stall reloads the shadow from `core_npc` rather than from the last written value.
- R9: Previous-PC reads return `core_ppc` (sampled at acceptance), whether the core is stalled or running.
- R10: Writes with the previous-PC selected produce no redirect and do not change the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Block can accept a request this cycle |
| dbg_req_write | input | 1 | 1 = write, 0 = read |
| dbg_req_sel | input | 1 | 0 = next-PC, 1 = previous-PC |
| dbg_req_wdata | input | 32 | Write data |
| dbg_rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| dbg_rsp_rdata | output | 32 | Read data of the response |
| core_stalled | input | 1 | Core is halted |
| core_npc | input | 32 | Core's live next-PC |
| core_ppc | input | 32 | Core's live previous-PC |
| core_redirect_valid | output | 1 | One-cycle redirect and flush request |
| core_redirect_pc | output | 32 | New fetch address of the redirect |

## Verification
The bench runs a sweep of stall sessions, each with its own arithmetically derived addresses. The core's entry next-PC, the value written, the previous-PC and the post-resume next-PC all differ between sessions, and the core reports zero after every flush. Reads after the stall begins tell shadow data apart from the flushed live value. Writes of the held value against writes of a fresh value separate dropping from forwarding. The running-mode writes of the live value show that dropping happens only while stalled. Re-stalling after a write shows whether the shadow reloads from the core or keeps stale data. Previous-PC reads and writes made in the middle of a session show that this register is kept apart from the shadow.

// File: rtl/pcsh_pkg.sv
package pcsh_pkg;
    localparam logic SEL_NPC = 1'b0;
    localparam logic SEL_PPC = 1'b1;
endpackage

// File: rtl/pcsh_shadow.sv
module pcsh_shadow #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stalled,
    input  logic [PC_W-1:0] live_pc,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    output logic [PC_W-1:0] shadow_pc,
    output logic            shadow_ok,
    output logic            differs
);
    typedef struct packed {
        logic            stall;
        logic            valid;
        logic [PC_W-1:0] pc;
    } shd_t;

    shd_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.stall = stalled;
        if (stalled && !s_q.stall) begin
            s_d.valid = 1'b1;
            s_d.pc    = live_pc;
        end
        if (!stalled && s_q.stall) begin
            s_d.valid = 1'b0;
        end
        if (wr_en && stalled) begin
            s_d.valid = 1'b1;
            s_d.pc    = wr_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow_pc = s_q.pc;
    assign shadow_ok = s_q.valid && stalled;
    assign differs   = (wr_pc != s_q.pc);

    // Leaving the stall drops the copy
    assert_unstall_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stall && !stalled) |=> !s_q.valid);

    // Entering the stall captures the live next-PC
    assert_stall_entry_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.stall && stalled && !wr_en) |=> (s_q.valid && s_q.pc == $past(live_pc)));
endmodule

// File: rtl/pcsh_port.sv
module pcsh_port
    import pcsh_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_sel,
    input  logic [PC_W-1:0] req_wdata,
    output logic            rsp_valid,
    output logic [PC_W-1:0] rsp_rdata,
    input  logic [PC_W-1:0] live_npc,
    input  logic [PC_W-1:0] live_ppc,
    input  logic [PC_W-1:0] shadow_pc,
    input  logic            shadow_ok,
    input  logic            differs,
    output logic            npc_wr,
    output logic            redir_valid,
    output logic [PC_W-1:0] redir_pc
);
    typedef struct packed {
        logic            rsp_valid;
        logic [PC_W-1:0] rsp_data;
        logic            redir_valid;
        logic [PC_W-1:0] redir_pc;
    } port_t;

    port_t p_d, p_q;
    logic  fire;
    logic  forward;

    assign req_ready = !p_q.rsp_valid;
    assign fire      = req_valid && req_ready;
    assign npc_wr    = fire && req_write && (req_sel == SEL_NPC);
    assign forward   = npc_wr && !(shadow_ok && !differs);

    always_comb begin
        p_d             = p_q;
        p_d.rsp_valid   = fire;
        p_d.redir_valid = forward;
        if (forward) p_d.redir_pc = req_wdata;
        if (fire) begin
            if (req_write)              p_d.rsp_data = '0;
            else if (req_sel == SEL_PPC) p_d.rsp_data = live_ppc;
            else if (shadow_ok)          p_d.rsp_data = shadow_pc;
            else                         p_d.rsp_data = live_npc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rsp_valid   = p_q.rsp_valid;
    assign rsp_rdata   = p_q.rsp_data;
    assign redir_valid = p_q.redir_valid;
    assign redir_pc    = p_q.redir_pc;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    assert_redir_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    assert_same_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_wr && shadow_ok && !differs) |=> !redir_valid);

    assert_running_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_wr && !shadow_ok) |=> (redir_valid && redir_pc == $past(req_wdata)));

    assert_ppc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_sel == SEL_PPC)
        |=> (rsp_rdata == $past(live_ppc)));
endmodule

// File: rtl/pc_shadow_bridge.sv
module pc_shadow_bridge #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_req_valid,
    output logic            dbg_req_ready,
    input  logic            dbg_req_write,
    input  logic            dbg_req_sel,
    input  logic [PC_W-1:0] dbg_req_wdata,
    output logic            dbg_rsp_valid,
    output logic [PC_W-1:0] dbg_rsp_rdata,
    input  logic            core_stalled,
    input  logic [PC_W-1:0] core_npc,
    input  logic [PC_W-1:0] core_ppc,
    output logic            core_redirect_valid,
    output logic [PC_W-1:0] core_redirect_pc
);
    logic [PC_W-1:0] shadow_pc;
    logic            shadow_ok;
    logic            differs;
    logic            npc_wr;

    pcsh_shadow #(.PC_W(PC_W)) shadow_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stalled   (core_stalled),
        .live_pc   (core_npc),
        .wr_en     (npc_wr),
        .wr_pc     (dbg_req_wdata),
        .shadow_pc (shadow_pc),
        .shadow_ok (shadow_ok),
        .differs   (differs)
    );

    pcsh_port #(.PC_W(PC_W)) port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (dbg_req_valid),
        .req_ready   (dbg_req_ready),
        .req_write   (dbg_req_write),
        .req_sel     (dbg_req_sel),
        .req_wdata   (dbg_req_wdata),
        .rsp_valid   (dbg_rsp_valid),
        .rsp_rdata   (dbg_rsp_rdata),
        .live_npc    (core_npc),
        .live_ppc    (core_ppc),
        .shadow_pc   (shadow_pc),
        .shadow_ok   (shadow_ok),
        .differs     (differs),
        .npc_wr      (npc_wr),
        .redir_valid (core_redirect_valid),
        .redir_pc    (core_redirect_pc)
    );
endmodule

// File: tb/pc_shadow_bridge_tb_top.sv
module pc_shadow_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SESSIONS   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_req_valid = 1'b0;
    logic        dbg_req_ready;
    logic        dbg_req_write = 1'b0;
    logic        dbg_req_sel = 1'b0;
    logic [31:0] dbg_req_wdata = '0;
    logic        dbg_rsp_valid;
    logic [31:0] dbg_rsp_rdata;
    logic        core_stalled = 1'b0;
    logic [31:0] core_npc = '0;
    logic [31:0] core_ppc = '0;
    logic        core_redirect_valid;
    logic [31:0] core_redirect_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_shadow_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
        .dbg_req_write(dbg_req_write), .dbg_req_sel(dbg_req_sel),
        .dbg_req_wdata(dbg_req_wdata), .dbg_rsp_valid(dbg_rsp_valid),
        .dbg_rsp_rdata(dbg_rsp_rdata), .core_stalled(core_stalled),
        .core_npc(core_npc), .core_ppc(core_ppc),
        .core_redirect_valid(core_redirect_valid),
        .core_redirect_pc(core_redirect_pc)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; checks response timing and the redirect pulse.
    task automatic access(input bit wr, input bit sel, input logic [31:0] wd,
                          input bit exp_redir, input logic [31:0] exp_data, input string tag);
        while (!dbg_req_ready) @(negedge clk);
        dbg_req_valid = 1'b1;
        dbg_req_write = wr;
        dbg_req_sel   = sel;
        dbg_req_wdata = wd;
        @(negedge clk);
        dbg_req_valid = 1'b0;
        check(dbg_rsp_valid && !dbg_req_ready, "R2 response timing", {30'd0, dbg_rsp_valid, dbg_req_ready}, 32'd2);
        check(dbg_rsp_rdata == exp_data, tag, dbg_rsp_rdata, exp_data);
        check(core_redirect_valid == exp_redir, {tag, " redirect"}, {31'd0, core_redirect_valid}, {31'd0, exp_redir});
        if (exp_redir)
            check(core_redirect_pc == wd, {tag, " redirect pc"}, core_redirect_pc, wd);
        @(negedge clk);
        check(!core_redirect_valid && !dbg_rsp_valid, "R4 single-cycle pulse", {31'd0, core_redirect_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] live0;
        repeat (2) @(negedge clk);
        check(!dbg_rsp_valid && !core_redirect_valid && dbg_req_ready, "R1 reset state",
              {29'd0, dbg_rsp_valid, core_redirect_valid, dbg_req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Running: pass-through and unconditional forwarding
        live0    = 32'h0000_0100;
        core_npc = live0;
        core_ppc = 32'h0000_00fc;
        access(1'b0, 1'b0, '0, 1'b0, live0, "R7 running read");
        access(1'b1, 1'b0, live0, 1'b1, 32'd0, "R7 running same-value write");
        access(1'b0, 1'b1, '0, 1'b0, 32'h0000_00fc, "R9 running ppc read");

        for (int k = 0; k < SESSIONS; k++) begin
            logic [31:0] entry, newpc, ppc, resume;
            entry  = 32'h0000_1000 + 32'(k) * 32'h40;
            newpc  = entry + 32'd4 * 32'(k + 1) + 32'h200;
            ppc    = entry - 32'd4;
            resume = newpc + 32'h10;

            core_npc     = entry;
            core_ppc     = ppc;
            core_stalled = 1'b1;
            repeat (2) @(negedge clk);
            core_npc = 32'd0;  // flushed pipeline reports zero

            access(1'b0, 1'b0, '0, 1'b0, entry, "R3 stalled read of captured next-PC");
            access(1'b1, 1'b0, entry, 1'b0, 32'd0, "R6 same-value write dropped");
            access(1'b0, 1'b0, '0, 1'b0, entry, "R6 read after dropped write");
            access(1'b1, 1'b0, newpc, 1'b1, 32'd0, "R4 changed write redirected");
            access(1'b0, 1'b0, '0, 1'b0, newpc, "R5 read returns written value");
            access(1'b1, 1'b0, newpc, 1'b0, 32'd0, "R6 rewrite of written value dropped");
            access(1'b1, 1'b1, 32'hdead_0000 + 32'(k), 1'b0, 32'd0, "R10 ppc write ignored");
            access(1'b0, 1'b0, '0, 1'b0, newpc, "R10 shadow intact after ppc write");
            access(1'b0, 1'b1, '0, 1'b0, ppc, "R9 stalled ppc read");

            core_stalled = 1'b0;
            core_npc     = resume;
            repeat (2) @(negedge clk);
            access(1'b0, 1'b0, '0, 1'b0, resume, "R8 read after unstall passes through");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule